// File: doc/BRIEF.md
# Banked Memory Management Decoder

This block sits between an 8-bit processor, a video fetch engine and the memory devices of a home computer with a 64 KB address space. An 8-bit control register selects the memory map. For every processor address and every video fetch address, the block works out which device answers the access and, for an extended-RAM access, which bank is used. The devices are main RAM, four 16 KB extended-RAM banks, an operating-system ROM, a BASIC ROM and a self-test ROM.

The processor and the video engine each have their own enable for the extended window. This lets the two requesters see different memory in the same 16 KB range in the same cycle. For example, the processor can edit a bank while the display keeps reading main RAM. ROM overlays apply only to processor accesses.

The control register is written through a plain strobe and data pair. A write takes effect at the next rising clock edge. Both decodes are combinational, so an address is decoded in the same cycle it is presented. There is no data stream through the block, so no valid/ready handshake is used. All pins are plain control and status pins.

Top module: `mmu_bank_decoder`

Target codes used on both target outputs: 0 = main RAM, 1 = extended RAM, 2 = OS ROM, 3 = BASIC ROM, 4 = self-test ROM.

## Requirements
- R1: After reset the control register holds 0xFF. In that state the processor sees OS ROM at 0xC000-0xFFFF and main RAM at every other address, and the video engine sees main RAM everywhere.
- R2: When `cfg_we` is high at a rising edge, `cfg_wdata` is loaded and governs the decode from that edge onward. When `cfg_we` is low, the register keeps its value whatever `cfg_wdata` carries.
- R3: When register bit 4 is 0, a processor address in 0x4000-0x7FFF (outside the self-test range of R8) decodes to extended RAM. No other processor address ever decodes to extended RAM.
- R4: When register bit 5 is 0, a video address in 0x4000-0x7FFF decodes to extended RAM. Otherwise the video engine sees main RAM there.
- R5: When bits 5 and 4 are both 1, neither requester sees extended RAM, whatever bits 3:2 hold.
- R6: A processor address in 0xC000-0xFFFF decodes to OS ROM when bit 0 is 1 and to main RAM when bit 0 is 0.
- R7: A processor address in 0xA000-0xBFFF decodes to BASIC ROM when bit 1 is 0 and to main RAM when bit 1 is 1.
- R8: A processor address in 0x5000-0x57FF decodes to self-test ROM when bit 7 is 0. This takes precedence over extended RAM.
- R9: The video target is only ever main RAM or extended RAM, whatever the register bits 0, 1 and 7 hold.
- R10: Each requester's bank output equals register bits 3:2 (00 to 11 = banks 0 to 3) when that requester's target is extended RAM, and 0 otherwise. Bit 6 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Control-register write strobe |
| cfg_wdata | input | 8 | Control-register write data |
| cpu_addr | input | 16 | Processor address |
| vid_addr | input | 16 | Video fetch address |
| cpu_target | output | 3 | Device chosen for the processor access |
| cpu_bank | output | 2 | Extended bank for the processor access |
| vid_target | output | 3 | Device chosen for the video access |
| vid_bank | output | 2 | Extended bank for the video access |

## Verification
The decode is combinational, so target and bank results are due in the same cycle as the address. The bench changes an address away from the clock edge and samples the outputs one nanosecond later. A register write is due at the first rising edge that sees the strobe. The bench therefore raises the strobe after a falling edge, drops it after the next falling edge, and only then checks the decode. The bench sweeps every one of the 256 register values against every 2 KB page of both address spaces, and also checks the first and last byte of each page.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int CFG_W  = 8;
  localparam int BANK_W = 2;
  localparam int TGT_W  = 3;

  // control register bit positions (decoded by the address decoders)
  localparam int B_OS      = 0;
  localparam int B_BASICN  = 1;
  localparam int B_BANK_LO = 2;
  localparam int B_CPU_MAIN = 4;
  localparam int B_VID_MAIN = 5;
  localparam int B_TESTN   = 7;

  typedef enum logic [TGT_W-1:0] {
    TGT_MAIN  = 3'd0,
    TGT_EXT   = 3'd1,
    TGT_OS    = 3'd2,
    TGT_BASIC = 3'd3,
    TGT_TEST  = 3'd4
  } target_e;
endpackage

// File: rtl/mmu_cfg_reg.sv
module mmu_cfg_reg
  import mmu_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_VAL = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= RESET_VAL;
    else if (we) cfg <= wdata;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> $stable(cfg)); // R2
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst)) |-> cfg == $past(wdata)); // R2
endmodule

// File: rtl/mmu_cpu_decode.sv
module mmu_cpu_decode
  import mmu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [ADDR_W-1:0] addr,
  output target_e           target,
  output logic [BANK_W-1:0] bank
);
  localparam int TOP = ADDR_W - 1;

  logic in_window, in_test, in_basic, in_os;

  always_comb begin
    in_window = addr[TOP -: 2] == 2'b01;
    in_test   = addr[TOP -: 5] == 5'b01010;
    in_basic  = addr[TOP -: 3] == 3'b101;
    in_os     = addr[TOP -: 2] == 2'b11;

    target = TGT_MAIN;
    if (in_os && cfg[B_OS])                   target = TGT_OS;
    else if (in_basic && !cfg[B_BASICN])      target = TGT_BASIC;
    else if (in_test && !cfg[B_TESTN])        target = TGT_TEST;
    else if (in_window && !cfg[B_CPU_MAIN])   target = TGT_EXT;

    bank = (target == TGT_EXT) ? cfg[B_BANK_LO +: BANK_W] : '0;
  end
endmodule

// File: rtl/mmu_vid_decode.sv
module mmu_vid_decode
  import mmu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [ADDR_W-1:0] addr,
  output target_e           target,
  output logic [BANK_W-1:0] bank
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    if ((addr[TOP -: 2] == 2'b01) && !cfg[B_VID_MAIN]) target = TGT_EXT;
    else                                               target = TGT_MAIN;
    bank = (target == TGT_EXT) ? cfg[B_BANK_LO +: BANK_W] : '0;
  end
endmodule

// File: rtl/mmu_bank_decoder.sv
module mmu_bank_decoder
  import mmu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [TGT_W-1:0]  cpu_target,
  output logic [BANK_W-1:0] cpu_bank,
  output logic [TGT_W-1:0]  vid_target,
  output logic [BANK_W-1:0] vid_bank
);
  logic [CFG_W-1:0] cfg;
  target_e cpu_t, vid_t;

  mmu_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  mmu_cpu_decode #(.ADDR_W(ADDR_W)) u_cpu (
    .cfg(cfg), .addr(cpu_addr), .target(cpu_t), .bank(cpu_bank)
  );

  mmu_vid_decode #(.ADDR_W(ADDR_W)) u_vid (
    .cfg(cfg), .addr(vid_addr), .target(vid_t), .bank(vid_bank)
  );

  assign cpu_target = cpu_t;
  assign vid_target = vid_t;

  AST_EXT_ONLY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (cpu_t == TGT_EXT) |-> (cpu_addr[ADDR_W-1 -: 2] == 2'b01)); // R3
  AST_VID_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (vid_t == TGT_EXT) |-> (vid_addr[ADDR_W-1 -: 2] == 2'b01)); // R4
  AST_COMPAT_MAIN: assert property (@(posedge clk) disable iff (rst)
    (cfg[B_VID_MAIN] && cfg[B_CPU_MAIN]) |-> (cpu_t != TGT_EXT && vid_t != TGT_EXT)); // R5
  AST_VID_NO_ROM: assert property (@(posedge clk) disable iff (rst)
    (vid_t == TGT_MAIN) || (vid_t == TGT_EXT)); // R9
  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_t != TGT_EXT) |-> (cpu_bank == '0)); // R10
  AST_VBANK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (vid_t != TGT_EXT) |-> (vid_bank == '0)); // R10
endmodule

// File: tb/sim_mmu_bank_decoder.sv
module sim_mmu_bank_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [15:0] cpu_addr = 16'h0000;
  logic [15:0] vid_addr = 16'h0000;
  logic [2:0] cpu_target, vid_target;
  logic [1:0] cpu_bank, vid_bank;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmu_bank_decoder u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cpu_addr(cpu_addr), .vid_addr(vid_addr),
    .cpu_target(cpu_target), .cpu_bank(cpu_bank),
    .vid_target(vid_target), .vid_bank(vid_bank)
  );

  function automatic logic [4:0] exp_cpu(input logic [7:0] c, input logic [15:0] a);
    int pg = a / 16'h0800;               // 2 KB page number
    logic [2:0] t;
    if (a >= 16'hC000 && c[0])                    t = 3'd2;
    else if (a >= 16'hA000 && a < 16'hC000 && !c[1]) t = 3'd3;
    else if (pg == 10 && !c[7])                   t = 3'd4;
    else if (a >= 16'h4000 && a < 16'h8000 && !c[4]) t = 3'd1;
    else                                          t = 3'd0;
    return {t, (t == 3'd1) ? c[3:2] : 2'd0};
  endfunction

  function automatic logic [4:0] exp_vid(input logic [7:0] c, input logic [15:0] a);
    logic ext = (a >= 16'h4000 && a < 16'h8000 && !c[5]);
    return {ext ? 3'd1 : 3'd0, ext ? c[3:2] : 2'd0};
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cfg-sweep addr=%h/%h actual tgt=%0d bank=%0d expected tgt=%0d bank=%0d",
               req, cpu_addr, vid_addr, act[4:2], act[1:0], exp[4:2], exp[1:0]);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic probe(input string req, input logic [7:0] c, input logic [15:0] a);
    cpu_addr = a; vid_addr = a;
    #1;
    check(req, {cpu_target, cpu_bank}, exp_cpu(c, a));
    check(req, {vid_target, vid_bank}, exp_vid(c, a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset map
    probe("R1", 8'hFF, 16'hC000);
    probe("R1", 8'hFF, 16'hA123);
    probe("R1", 8'hFF, 16'h5000);
    probe("R1", 8'hFF, 16'h4000);
    // R2: strobe low leaves register untouched
    @(negedge clk); cfg_wdata = 8'h00;
    @(negedge clk); @(negedge clk);
    probe("R2", 8'hFF, 16'hC000);
    probe("R2", 8'hFF, 16'h4800);
    write_cfg(8'h0C);
    probe("R2", 8'h0C, 16'h6000);
    // full sweep R3..R10: all register values x every page start/end
    for (int c = 0; c < 256; c++) begin
      write_cfg(c[7:0]);
      for (int p = 0; p < 32; p++) begin
        probe("R3-R10", c[7:0], 16'(p * 16'h0800));
        probe("R3-R10", c[7:0], 16'(p * 16'h0800 + 16'h07FF));
      end
    end
    // named corner cases
    write_cfg(8'h6F); probe("R3", 8'h6F, 16'h4000); probe("R3", 8'h6F, 16'h8000);
    write_cfg(8'h5B); probe("R4", 8'h5B, 16'h7FFF); probe("R4", 8'h5B, 16'h3FFF);
    write_cfg(8'h3C); probe("R5", 8'h3C, 16'h4000);
    write_cfg(8'hFE); probe("R6", 8'hFE, 16'hFFFF);
    write_cfg(8'hFD); probe("R7", 8'hFD, 16'hBFFF);
    write_cfg(8'h4C); probe("R8", 8'h4C, 16'h57FF); probe("R8", 8'h4C, 16'h5800);
    write_cfg(8'h00); probe("R9", 8'h00, 16'hC000); probe("R9", 8'h00, 16'h5000);
    write_cfg(8'h88); probe("R10", 8'h88, 16'h4000);
    write_cfg(8'hC8); probe("R10", 8'hC8, 16'h4000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual running expected done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule